// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard-control logic for a five-stage in-order integer pipeline that resolves branches in decode. It compares source register numbers with the destination numbers held in the later pipeline registers. From that comparison it picks a bypass source for each ALU operand and for each input of the decode-stage equality comparator. When a bypass cannot supply a value in time, it stalls the front of the pipeline.

A stall holds the PC and the IF/ID register and loads a no-op into ID/EX. A taken branch, which the comparator result and the decode branch flag identify, clears IF/ID on the next clock. That discards the one instruction fetched sequentially behind the branch. The unit is purely combinational. The surrounding datapath registers its outputs through the pipeline registers and the PC.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each ALU operand select (`fwd_a` for the ID/EX rs field, `fwd_b` for the ID/EX rt field) is 2'd0 for the register-file value, 2'd1 for the EX/MEM result and 2'd2 for the MEM/WB result. It never takes 2'd3. It is 2'd1 when EX/MEM writes a nonzero register equal to that source.
- R2: An ALU operand select is 2'd2 when MEM/WB writes a nonzero register equal to the source and EX/MEM does not supply that source.
- R3: When EX/MEM and MEM/WB both write the same source register, the ALU select is 2'd1, because the younger result wins.
- R4: Register 0 never matches. A stage whose write flag is low never matches. Every select is 2'd0 in these cases.
- R5: The branch-comparator selects (`fwd_ca` for the ID rs field, `fwd_cb` for the ID rt field) use the same encoding. They forward from EX/MEM only when the instruction there is not a load, and otherwise from MEM/WB. EX/MEM takes priority.
- R6: A load in ID/EX whose nonzero destination equals either ID source raises `hold` for that cycle.
- R7: A branch in ID raises `hold` while any register-writing instruction in ID/EX targets one of its nonzero sources. Together with R8, this gives one stall behind an ALU producer and two stalls behind a load.
- R8: A branch in ID raises `hold` while a load in EX/MEM targets one of its nonzero sources.
- R9: `bubble` equals `hold` in every cycle.
- R10: `flush` is high when a branch in ID finds its operands equal and `hold` is low. A stall suppresses the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | rs field of the instruction in decode |
| id_rt | input | REG_W | rt field of the instruction in decode |
| id_branch | input | 1 | decode holds a conditional branch |
| id_cmp_eq | input | 1 | decode equality comparator result |
| idex_rs | input | REG_W | rs field in ID/EX |
| idex_rt | input | REG_W | rt field in ID/EX |
| idex_rd | input | REG_W | destination in ID/EX |
| idex_wr | input | 1 | ID/EX instruction writes a register |
| idex_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | REG_W | destination in EX/MEM |
| exmem_wr | input | 1 | EX/MEM instruction writes a register |
| exmem_load | input | 1 | EX/MEM instruction is a load |
| memwb_rd | input | REG_W | destination in MEM/WB |
| memwb_wr | input | 1 | MEM/WB instruction writes a register |
| fwd_a | output | 2 | ALU operand A source select |
| fwd_b | output | 2 | ALU operand B source select |
| fwd_ca | output | 2 | branch comparator input A select |
| fwd_cb | output | 2 | branch comparator input B select |
| hold | output | 1 | freeze PC and IF/ID |
| bubble | output | 1 | load a no-op into ID/EX |
| flush | output | 1 | clear IF/ID for a taken branch |

## Verification
The assertions assume the flag inputs are consistent, meaning a load flag is only set together with that stage's write flag. The bench stimulus always sets a load flag with its matching write flag, and it draws register numbers from a small range so that source and destination matches are frequent. The assertions also assume that ALU forwarding never has to cover a load sitting in EX/MEM. The R6 stall creates that condition in a real pipeline. The bench checks the forwarding selects as pure functions of the fields, so no scenario depends on that assumption.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_branch,
  input  logic             id_cmp_eq,
  input  logic [REG_W-1:0] idex_rs,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [REG_W-1:0] idex_rd,
  input  logic             idex_wr,
  input  logic             idex_load,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_wr,
  input  logic             exmem_load,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_wr,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic [1:0]       fwd_ca,
  output logic [1:0]       fwd_cb,
  output logic             hold,
  output logic             bubble,
  output logic             flush
);
  localparam logic [REG_W-1:0] ZERO = '0;
  localparam logic [1:0] SEL_RF = 2'd0, SEL_EXM = 2'd1, SEL_MWB = 2'd2;

  logic ex_live, em_live, mw_live;
  assign ex_live = idex_wr  && (idex_rd  != ZERO);
  assign em_live = exmem_wr && (exmem_rd != ZERO);
  assign mw_live = memwb_wr && (memwb_rd != ZERO);

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src,
                                      input logic em_ok, input logic mw_ok);
    if (em_ok && exmem_rd == src)      return SEL_EXM;
    else if (mw_ok && memwb_rd == src) return SEL_MWB;
    else                               return SEL_RF;
  endfunction

  assign fwd_a  = pick(idex_rs, em_live, mw_live);
  assign fwd_b  = pick(idex_rt, em_live, mw_live);
  assign fwd_ca = pick(id_rs, em_live && !exmem_load, mw_live);
  assign fwd_cb = pick(id_rt, em_live && !exmem_load, mw_live);

  logic ex_hits_id, em_hits_id, load_use, br_ex, br_mem;
  assign ex_hits_id = ex_live && (idex_rd == id_rs || idex_rd == id_rt);
  assign em_hits_id = em_live && (exmem_rd == id_rs || exmem_rd == id_rt);
  assign load_use   = idex_load && ex_hits_id;
  assign br_ex      = id_branch && ex_hits_id;
  assign br_mem     = id_branch && exmem_load && em_hits_id;

  assign hold   = load_use || br_ex || br_mem;
  assign bubble = hold;
  assign flush  = id_branch && id_cmp_eq && !hold;

  always_comb begin
    a_r1_alu_sel_legal: assert (fwd_a != 2'd3 && fwd_b != 2'd3);
    a_r5_cmp_sel_legal: assert (fwd_ca != 2'd3 && fwd_cb != 2'd3);
    a_r4_zero_never_fwd: assert (idex_rs != ZERO || fwd_a == SEL_RF);
    a_r5_no_load_bypass: assert (!(exmem_load && fwd_ca == SEL_EXM));
    a_r10_stall_beats_flush: assert (!(hold && flush));
    a_r9_bubble_tracks_hold: assert (bubble == hold);
  end
endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
  localparam int REG_W = 5;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0] id_rs, id_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd;
  logic id_branch, id_cmp_eq, idex_wr, idex_load, exmem_wr, exmem_load, memwb_wr;
  logic [1:0] fwd_a, fwd_b, fwd_ca, fwd_cb;
  logic hold, bubble, flush;

  hazard_fwd_unit #(.REG_W(REG_W)) dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_sel(logic [REG_W-1:0] s, logic em_ok, logic mw_ok);
    if (em_ok && exmem_wr && exmem_rd != 0 && exmem_rd == s) return 1;
    if (mw_ok && memwb_wr && memwb_rd != 0 && memwb_rd == s) return 2;
    return 0;
  endfunction

  function automatic int ref_hold();
    logic exm, emm;
    exm = idex_wr && idex_rd != 0 && (idex_rd == id_rs || idex_rd == id_rt);
    emm = exmem_wr && exmem_rd != 0 && (exmem_rd == id_rs || exmem_rd == id_rt);
    return int'((idex_load && exm) || (id_branch && exm) || (id_branch && exmem_load && emm));
  endfunction

  task automatic clear();
    {id_rs, id_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd} = '0;
    {id_branch, id_cmp_eq, idex_wr, idex_load, exmem_wr, exmem_load, memwb_wr} = '0;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    clear(); step();
    chk("R4 idle fwd_a", fwd_a, 0); chk("R9 idle hold", hold, 0); chk("R10 idle flush", flush, 0);

    clear(); idex_rs = 8; exmem_wr = 1; exmem_rd = 8; step();
    chk("R1 exmem fwd_a", fwd_a, 1); chk("R1 fwd_b none", fwd_b, 0);
    clear(); idex_rt = 9; memwb_wr = 1; memwb_rd = 9; step();
    chk("R2 memwb fwd_b", fwd_b, 2);
    clear(); idex_rs = 8; exmem_wr = 1; exmem_rd = 8; memwb_wr = 1; memwb_rd = 8; step();
    chk("R3 priority fwd_a", fwd_a, 1);
    clear(); idex_rs = 0; exmem_wr = 1; exmem_rd = 0; memwb_wr = 1; memwb_rd = 0; step();
    chk("R4 reg0 fwd_a", fwd_a, 0);
    clear(); idex_rs = 7; exmem_rd = 7; memwb_rd = 7; step();
    chk("R4 no write flag", fwd_a, 0);
    clear(); id_rs = 8; exmem_wr = 1; exmem_load = 1; exmem_rd = 8; memwb_wr = 1; memwb_rd = 8; step();
    chk("R5 cmp skips load", fwd_ca, 2);
    clear(); id_rt = 9; exmem_wr = 1; exmem_rd = 9; step();
    chk("R5 cmp exmem", fwd_cb, 1);
    clear(); id_rt = 9; idex_wr = 1; idex_load = 1; idex_rd = 9; step();
    chk("R6 load-use hold", hold, 1); chk("R9 bubble", bubble, 1);
    clear(); id_branch = 1; id_cmp_eq = 1; id_rs = 8; idex_wr = 1; idex_rd = 8; step();
    chk("R7 branch on EX alu", hold, 1); chk("R10 flush blocked", flush, 0);
    clear(); id_branch = 1; id_rs = 8; exmem_wr = 1; exmem_load = 1; exmem_rd = 8; step();
    chk("R8 branch on MEM load", hold, 1);
    clear(); id_branch = 1; id_rs = 8; exmem_wr = 1; exmem_rd = 8; step();
    chk("R7 no stall alu in MEM", hold, 0);
    clear(); id_branch = 1; id_cmp_eq = 1; id_rs = 3; id_rt = 4; step();
    chk("R10 taken flush", flush, 1);
    clear(); id_branch = 0; id_cmp_eq = 1; step();
    chk("R10 not branch", flush, 0);

    for (int i = 0; i < 3000; i++) begin
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      idex_rs = 5'($urandom_range(0, 3)); idex_rt = 5'($urandom_range(0, 3));
      idex_rd = 5'($urandom_range(0, 3)); exmem_rd = 5'($urandom_range(0, 3));
      memwb_rd = 5'($urandom_range(0, 3));
      id_branch = 1'($urandom); id_cmp_eq = 1'($urandom);
      idex_wr = 1'($urandom); idex_load = idex_wr & 1'($urandom);
      exmem_wr = 1'($urandom); exmem_load = exmem_wr & 1'($urandom);
      memwb_wr = 1'($urandom);
      step();
      chk("R1/R2/R3/R4 rnd fwd_a", fwd_a, ref_sel(idex_rs, 1, 1));
      chk("R1/R2/R3/R4 rnd fwd_b", fwd_b, ref_sel(idex_rt, 1, 1));
      chk("R5 rnd fwd_ca", fwd_ca, ref_sel(id_rs, !exmem_load, 1));
      chk("R5 rnd fwd_cb", fwd_cb, ref_sel(id_rt, !exmem_load, 1));
      chk("R6/R7/R8 rnd hold", hold, ref_hold());
      chk("R9 rnd bubble", bubble, ref_hold());
      chk("R10 rnd flush", flush, int'(id_branch && id_cmp_eq && ref_hold() == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule